// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a small fully associative translation buffer. It maps a 32-bit effective address to a 32-bit physical address. Each of its entries carries six fields: a valid flag, an effective page number, a page-size code, an owner tag, a physical page number, and, implicitly, the address bits it compares. Because every entry chooses its own page size, between 1 KB and 16 MB, every entry compares and replaces a different number of upper address bits.

Software loads one entry per cycle through the write port. The entry's owner tag is taken from the current process-ID input at the moment of the write. A one-cycle invalidate strobe empties the whole buffer. The lookup port is purely combinational. It takes an address and the current process ID, and in the same cycle returns hit, miss, the winning index, a multi-match flag and the translated address. An owner tag of zero marks an entry as shared by every process.

Top module: `pgtlb`

## Requirements
- R1: The page-size code `sz` (3 bits, values 0 through 7 meaning 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB) sets how many of the address bits `ea[31:10]` are compared with the stored page number. The count is 22 − 2·sz, counted down from bit 31. The lower stored page-number bits are ignored.
- R2: An entry whose valid flag is clear never matches.
- R3: An entry with owner tag 0x00 matches under any process ID. An entry with any other tag matches only when its tag equals `pid`.
- R4: A write (`wr_en` high, `inval_all` low) stores the page number, size and physical page number at `wr_idx`. It takes the owner tag from `pid` in that same cycle and sets the entry valid from the next cycle on.
- R5: On a hit, the compared upper bits of the address are replaced by the same-position bits of the entry's physical page number. All bits below the page boundary, including `ea[9:0]`, pass through to `lk_pa` unchanged.
- R6: Physical-page-number bits below the page boundary are ignored when the address is formed. `wr_rpn_err` is high in a write cycle exactly when any of those bits in `wr_rpn` is 1. It is always low for size code 0.
- R7: `inval_all` clears every valid flag at the next clock edge. A write in the same cycle is overridden, so the written entry ends up invalid.
- R8: When several entries match, the lowest index is reported in `lk_idx` and used for translation, and `lk_multi` is high. With exactly one match or none, `lk_multi` is low.
- R9: `lk_miss` is the complement of `lk_hit`. On a miss, `lk_pa` and `lk_idx` are 0.
- R10: After reset, every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pid | input | 8 | Current process ID, used for lookup matching and captured on a write |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 3 | Entry index to write |
| wr_epn | input | 22 | Effective page number to store |
| wr_size | input | 3 | Page-size code to store |
| wr_rpn | input | 22 | Physical page number to store |
| wr_rpn_err | output | 1 | Nonzero physical-page-number bits below the page boundary on this write |
| inval_all | input | 1 | Invalidate every entry |
| lk_ea | input | 32 | Lookup effective address |
| lk_hit | output | 1 | At least one entry matches |
| lk_miss | output | 1 | No entry matches |
| lk_idx | output | 3 | Index of the winning entry |
| lk_pa | output | 32 | Translated physical address |
| lk_multi | output | 1 | More than one entry matches |

## Verification
The buffer is filled with one entry of each of the eight sizes. Most entries get distinct owner tags; one gets tag zero. Each entry is then probed in four ways:
- an address inside its page with a random offset, which exposes a wrong compare width or a wrong offset split;
- the same address with the bit just above the page boundary flipped, which must now fall on a different page;
- a matching process ID and a wrong process ID, which separate the tag-zero wildcard from exact tag matching;
- the bit just below the boundary flipped, which must stay on the same page.

Random addresses add misses. Nested pages of 16 MB, 4 KB and 1 KB test the index priority and the multi-match flag. Writes with junk in the low physical-page-number bits check that those bits are both flagged and ignored. A write issued together with invalidate checks the priority between the two.

// File: rtl/pgtlb.sv
module pgtlb #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PN_W    = 22,
  parameter int SZ_W    = 3,
  parameter int TID_W   = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] pid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PN_W-1:0]  wr_epn,
  input  logic [SZ_W-1:0]  wr_size,
  input  logic [PN_W-1:0]  wr_rpn,
  output logic             wr_rpn_err,
  input  logic             inval_all,
  input  logic [VA_W-1:0]  lk_ea,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [IDX_W-1:0] lk_idx,
  output logic [VA_W-1:0]  lk_pa,
  output logic             lk_multi
);
  localparam int OFF_W = VA_W - PN_W;

  function automatic logic [PN_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    return {PN_W{1'b1}} << (2 * sz);
  endfunction

  logic             vld   [ENTRIES];
  logic [PN_W-1:0]  epn_q [ENTRIES];
  logic [PN_W-1:0]  rpn_q [ENTRIES];
  logic [SZ_W-1:0]  sz_q  [ENTRIES];
  logic [TID_W-1:0] tid_q [ENTRIES];
  logic [PN_W-1:0]  pmask [ENTRIES];
  logic [ENTRIES-1:0] match;

  wire [PN_W-1:0] ea_pn = lk_ea[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    wire sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g]   <= 1'b0;
        epn_q[g] <= '0;
        rpn_q[g] <= '0;
        sz_q[g]  <= '0;
        tid_q[g] <= '0;
      end else if (inval_all) begin
        vld[g] <= 1'b0;
      end else if (sel) begin
        vld[g]   <= 1'b1;
        epn_q[g] <= wr_epn;
        rpn_q[g] <= wr_rpn;
        sz_q[g]  <= wr_size;
        tid_q[g] <= pid;
      end
    end

    assign pmask[g] = page_mask(sz_q[g]);
    assign match[g] = vld[g]
                   && (((ea_pn ^ epn_q[g]) & pmask[g]) == '0)
                   && (tid_q[g] == '0 || tid_q[g] == pid);
  end

  always_comb begin
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) lk_idx = IDX_W'(i);
  end

  assign lk_hit   = |match;
  assign lk_miss  = ~lk_hit;
  assign lk_multi = (match & (match - 1'b1)) != '0;

  assign lk_pa = lk_hit
    ? {(rpn_q[lk_idx] & pmask[lk_idx]) | (ea_pn & ~pmask[lk_idx]), lk_ea[OFF_W-1:0]}
    : '0;

  assign wr_rpn_err = wr_en && ((wr_rpn & ~page_mask(wr_size)) != '0);
endmodule

module pgtlb_chk #(
  parameter int VA_W  = 32,
  parameter int PN_W  = 22,
  parameter int SZ_W  = 3,
  parameter int TID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TID_W-1:0] pid,
  input logic             wr_en,
  input logic [PN_W-1:0]  wr_epn,
  input logic [SZ_W-1:0]  wr_size,
  input logic             wr_rpn_err,
  input logic             inval_all,
  input logic [VA_W-1:0]  lk_ea,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic [VA_W-1:0]  lk_pa,
  input logic             lk_multi
);
  localparam int OFF_W = VA_W - PN_W;

  // R7
  inval_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !lk_hit);

  // R8
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  // R9
  miss_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (!lk_hit && lk_pa == '0));

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[OFF_W-1:0] == lk_ea[OFF_W-1:0]);

  // R4
  write_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inval_all) |=>
      (!(lk_ea[VA_W-1:OFF_W] == $past(wr_epn) && pid == $past(pid)) || lk_hit));

  // R6
  small_page_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == '0) |-> !wr_rpn_err);
endmodule

bind pgtlb pgtlb_chk #(.VA_W(VA_W), .PN_W(PN_W), .SZ_W(SZ_W), .TID_W(TID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pid(pid), .wr_en(wr_en), .wr_epn(wr_epn),
  .wr_size(wr_size), .wr_rpn_err(wr_rpn_err), .inval_all(inval_all),
  .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
  .lk_multi(lk_multi)
);

// File: tb/pgtlb_tb_top.sv
module pgtlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pid = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [21:0] wr_epn = '0;
  logic [2:0]  wr_size = '0;
  logic [21:0] wr_rpn = '0;
  logic        wr_rpn_err;
  logic        inval_all = 1'b0;
  logic [31:0] lk_ea = '0;
  logic        lk_hit, lk_miss, lk_multi;
  logic [2:0]  lk_idx;
  logic [31:0] lk_pa;

  int checks = 0;
  int failures = 0;

  bit          m_v   [8];
  logic [21:0] m_epn [8];
  logic [21:0] m_rpn [8];
  logic [2:0]  m_sz  [8];
  logic [7:0]  m_tid [8];

  always #10 clk = ~clk;

  pgtlb dut_i (
    .clk(clk), .rst_n(rst_n), .pid(pid), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_epn(wr_epn), .wr_size(wr_size), .wr_rpn(wr_rpn), .wr_rpn_err(wr_rpn_err),
    .inval_all(inval_all), .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_idx(lk_idx), .lk_pa(lk_pa), .lk_multi(lk_multi)
  );

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
  endtask

  task automatic write_entry(input int idx, input logic [21:0] epn, input logic [2:0] sz,
                             input logic [21:0] rpn, input logic [7:0] p, input bit inv);
    int sh;
    bit exp_err;
    @(negedge clk);
    pid = p; wr_en = 1'b1; wr_idx = 3'(idx); wr_epn = epn; wr_size = sz; wr_rpn = rpn;
    inval_all = inv;
    #5;
    sh = 2 * int'(sz);
    exp_err = (rpn % (22'd1 << sh)) != 0;
    checks++;
    if (wr_rpn_err !== exp_err) begin
      failures++;
      $display("FAIL R6 rpn_err idx=%0d act=%b exp=%b", idx, wr_rpn_err, exp_err);
    end
    @(negedge clk);
    wr_en = 1'b0; inval_all = 1'b0;
    if (inv) model_clear();
    else begin
      m_v[idx] = 1'b1; m_epn[idx] = epn; m_sz[idx] = sz; m_rpn[idx] = rpn; m_tid[idx] = p;
    end
  endtask

  task automatic do_inval();
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    model_clear();
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [7:0] p, input string tag);
    bit e_hit = 0, e_multi = 0;
    int e_idx = 0;
    logic [31:0] e_pa = '0;
    int sh;
    logic [31:0] lo;
    for (int i = 7; i >= 0; i--) begin
      sh = 10 + 2 * int'(m_sz[i]);
      if (m_v[i] && ((ea >> sh) == ({m_epn[i], 10'b0} >> sh))
          && (m_tid[i] == 0 || m_tid[i] == p)) begin
        if (e_hit) e_multi = 1;
        e_hit = 1; e_idx = i;
      end
    end
    if (e_hit) begin
      sh = 10 + 2 * int'(m_sz[e_idx]);
      lo = (32'd1 << sh) - 1;
      e_pa = ({m_rpn[e_idx], 10'b0} & ~lo) | (ea & lo);
    end
    @(negedge clk);
    lk_ea = ea; pid = p;
    #5;
    checks++;
    if (lk_hit !== e_hit || lk_miss !== !e_hit || lk_multi !== e_multi
        || lk_idx !== 3'(e_idx) || lk_pa !== e_pa) begin
      failures++;
      $display("FAIL %s ea=%h pid=%h act hit=%b miss=%b idx=%0d pa=%h multi=%b exp hit=%b idx=%0d pa=%h multi=%b",
               tag, ea, p, lk_hit, lk_miss, lk_idx, lk_pa, lk_multi, e_hit, e_idx, e_pa, e_multi);
    end
  endtask

  initial begin
    #4000000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [21:0] epn, rpn;
    logic [31:0] base, ea;
    int sh;
    model_clear();
    for (int i = 0; i < 8; i++) begin
      m_epn[i] = '0; m_rpn[i] = '0; m_sz[i] = '0; m_tid[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset leaves every entry invalid
    lookup(32'h0000_0000, 8'h00, "R10 reset");
    lookup(32'hFFFF_FFFF, 8'h00, "R10 reset");
    lookup(32'h1234_5678, 8'h5A, "R10 reset");

    // R1 R3 R4 R6: one entry per page size, entry 3 shared (tag 0)
    for (int i = 0; i < 8; i++) begin
      epn = 22'($urandom);
      rpn = 22'($urandom);
      if (i % 2 == 0) rpn = rpn & ~((22'd1 << (2 * i)) - 1);
      write_entry(i, epn, 3'(i), rpn, (i == 3) ? 8'h00 : 8'(8'h10 + i), 1'b0);
    end

    // R1 R2 R3 R5 R8 R9: probe each entry
    for (int i = 0; i < 8; i++) begin
      sh = 10 + 2 * i;
      base = ({m_epn[i], 10'b0} >> sh) << sh;
      for (int k = 0; k < 6; k++) begin
        ea = base | ($urandom & ((32'd1 << sh) - 1));
        lookup(ea, m_tid[i], "R1 R5 in-page");
        lookup(ea, 8'hEE, "R3 wrong pid");
        lookup(ea ^ (32'd1 << sh), m_tid[i], "R1 above-boundary");
        lookup(ea ^ (32'd1 << (sh - 1)), m_tid[i], "R1 below-boundary");
      end
      lookup(base, 8'h00, "R3 pid zero");
    end
    for (int k = 0; k < 300; k++)
      lookup($urandom, 8'($urandom % 24), "R9 random");

    // R7: write together with invalidate loses
    write_entry(1, 22'h2A_AAAA, 3'd2, 22'h15_5554, 8'h21, 1'b1);
    lookup({22'h2A_AAAA, 10'h155}, 8'h21, "R7 write+inval");
    lookup({m_epn[3], 10'h000}, 8'h00, "R7 all cleared");

    // R8: nested pages, lowest index wins
    write_entry(5, 22'h3C_0000, 3'd7, 22'h08_0000, 8'h00, 1'b0);
    write_entry(2, 22'h3C_1234, 3'd1, 22'h11_1110, 8'h00, 1'b0);
    write_entry(6, 22'h3C_1237, 3'd0, 22'h22_2222, 8'h00, 1'b0);
    for (int k = 0; k < 20; k++) begin
      lookup({22'h3C_1234 | 22'($urandom % 4), 10'($urandom)}, 8'h33, "R8 nested");
      lookup({8'hF0, 24'($urandom)}, 8'h33, "R8 outer");
    end

    // R6: junk low rpn bits flagged and ignored
    write_entry(4, 22'h01_0101, 3'd3, 22'h2F_FFFF, 8'h44, 1'b0);
    write_entry(0, 22'h02_0202, 3'd0, 22'h3F_FFFF, 8'h45, 1'b0);
    for (int k = 0; k < 10; k++) begin
      lookup({22'h01_0100, 10'b0} | ($urandom & 32'hFFFF), 8'h44, "R6 ignored low rpn");
      lookup({22'h02_0202, 10'($urandom)}, 8'h45, "R6 size0");
    end

    // R2 R7: stale entries after invalidate all miss
    do_inval();
    lookup({22'h01_0101, 10'h0}, 8'h44, "R2 invalid");
    lookup({22'h3C_1237, 10'h3}, 8'h00, "R2 invalid");
    // R4: rewrite after invalidate hits again
    write_entry(7, 22'h01_0101, 3'd4, 22'h0A_BC00, 8'h44, 1'b0);
    lookup({22'h01_0101, 10'h2F}, 8'h44, "R4 rewrite");
    lookup({22'h01_0101, 10'h2F}, 8'h43, "R3 R4 tag captured");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule